// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles parity for one agent on a shared 32-bit multiplexed address/data bus that carries four command/byte-enable lines beside it. Each transfer the agent takes part in is marked by a phase indicator: address, write data or read data. The agent's role, initiator or target, decides two things for that transfer. If this agent placed the transfer on the bus, the block drives the parity line one clock later. If another agent placed it there, the block checks the parity line that arrives one clock later.

The block drives the parity line as a value plus an output-enable. Data parity mismatches appear on an active-low data error output. Address parity mismatches appear as a one-clock active-low pulse on a system error output. A checking enable turns off both error outputs and leaves parity generation running. The reset input is asynchronous and active low. Inside the block it is released in step with the clock.

Top module: `bus_par_unit`

## Requirements
- R1: When `par_oe_o` is high, `par_o` makes the XOR of itself, the 32 `ad_i` bits and the 4 `cbe_i` bits that were sampled at the previous rising edge equal to 0 (even parity over 37 bits).
- R2: Parity and its enable are registered. They change only after the rising edge that samples the phase, so they are valid during the following clock and not during the phase clock itself.
- R3: The block drives parity (`par_oe_o` = 1) after an address or write-data phase when `is_init_i` = 1, and after a read-data phase when `is_init_i` = 0.
- R4: After any clock in which R3 does not apply, `par_oe_o` is 0 and `par_o` is 0. The enable therefore lasts one clock per driven phase.
- R5: A data phase is checked by the agent that received the data: the target (`is_init_i` = 0) for write data and the initiator (`is_init_i` = 1) for read data. If `par_i` in the next clock does not give even parity with that phase's `ad_i`/`cbe_i`, `perr_n_o` is 0 for one clock starting at the following edge, so it is seen at the second edge after the transfer.
- R6: An address phase seen as target (`is_init_i` = 0) is checked the same way. A mismatch gives a single one-clock low pulse on `serr_n_o`, with the same timing as R5.
- R7: When `chk_en_i` is 0 in the phase clock, that phase raises no error on either output. Parity generation per R3 continues unchanged.
- R8: While reset is low, `par_oe_o` = 0, `par_o` = 0, `perr_n_o` = 1 and `serr_n_o` = 1. Reset takes effect without waiting for a clock edge and also cancels any error that is still pending.
- R9: Consecutive erroneous data phases give consecutive low clocks on `perr_n_o`, one clock for each phase.
- R10: A phase that this agent drove is never checked against `par_i`, so a wrong `par_i` after it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bus value |
| cbe_i | input | 4 | Command/byte-enable bus value |
| par_i | input | 1 | Parity line value as observed on the bus |
| addr_ph_i | input | 1 | Address phase transfers this clock |
| wdat_ph_i | input | 1 | Write data phase transfers this clock |
| rdat_ph_i | input | 1 | Read data phase transfers this clock |
| is_init_i | input | 1 | 1 = this agent is initiator, 0 = target |
| chk_en_i | input | 1 | Parity checking enable |
| par_o | output | 1 | Parity value driven by this agent |
| par_oe_o | output | 1 | Output-enable for `par_o` |
| perr_n_o | output | 1 | Data parity error, active low |
| serr_n_o | output | 1 | Address parity error pulse, active low |

## Verification
The hardest situation to reach from the ports is the overlap of pipelines. An error output always reports the phase from two clocks earlier, while the parity output reports the phase from one clock earlier. A single stimulus clock therefore carries the parity for the previous phase and the data for the next phase. The vector table chains phases back to back so that each row sets the parity for the row before it. This includes two erroneous target writes in a row, a driven read followed by a deliberately wrong parity, and a mismatch that arrives while checking is off. A directed sequence then asserts reset in the clock between a bad write and its error report, to show that the pending error is dropped.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
  localparam int AD_W  = 32;
  localparam int CBE_W = 4;

  typedef struct packed {
    logic addr;
    logic wdat;
    logic rdat;
  } phase_t;
endpackage

// File: rtl/bpar_xor_tree.sv
module bpar_xor_tree #(
  parameter int W = 36
) (
  input  logic [W-1:0] d_i,
  output logic         odd_o
);
  localparam int LV = (W > 1) ? $clog2(W) : 1;
  localparam int P  = 1 << LV;

  logic [2*P-2:0] node;

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < W) begin : g_used
      assign node[P-1+i] = d_i[i];
    end else begin : g_pad
      assign node[P-1+i] = 1'b0;
    end
  end

  for (genvar k = 0; k < P-1; k++) begin : g_node
    assign node[k] = node[2*k+1] ^ node[2*k+2];
  end

  assign odd_o = node[0];
endmodule

// File: rtl/bpar_rst_sync.sv
module bpar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q = sh_q[STAGES-1];
endmodule

// File: rtl/bpar_drive.sv
module bpar_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_i,
  input  logic odd_i,
  output logic par_o,
  output logic oe_o
);
  logic par_q, par_d;
  logic oe_q, oe_d;

  always_comb begin
    oe_d  = drive_i;
    par_d = drive_i & odd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= par_d;
      oe_q  <= oe_d;
    end
  end

  assign par_o = par_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/bpar_check.sv
module bpar_check (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic odd_i,
  input  logic par_i,
  output logic err_o
);
  logic arm_q, arm_d;
  logic exp_q, exp_d;
  logic err_q, err_d;

  always_comb begin
    arm_d = arm_i;
    exp_d = arm_i ? odd_i : exp_q;
    err_d = arm_q & (exp_q ^ par_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      exp_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      arm_q <= arm_d;
      if (arm_i) exp_q <= exp_d;
      err_q <= err_d;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/bus_par_unit.sv
module bus_par_unit
  import bpar_pkg::*;
#(
  parameter int ADW  = AD_W,
  parameter int CBEW = CBE_W,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ADW-1:0]  ad_i,
  input  logic [CBEW-1:0] cbe_i,
  input  logic            par_i,
  input  logic            addr_ph_i,
  input  logic            wdat_ph_i,
  input  logic            rdat_ph_i,
  input  logic            is_init_i,
  input  logic            chk_en_i,
  output logic            par_o,
  output logic            par_oe_o,
  output logic            perr_n_o,
  output logic            serr_n_o
);
  localparam int TOT_W = ADW + CBEW;

  logic   rst_q;
  logic   odd;
  phase_t ph;
  logic   drive, data_arm, addr_arm;
  logic   data_err, addr_err;

  bpar_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  bpar_xor_tree #(.W(TOT_W)) u_tree (
    .d_i({ad_i, cbe_i}), .odd_o(odd)
  );

  always_comb begin
    ph       = '{addr: addr_ph_i, wdat: wdat_ph_i, rdat: rdat_ph_i};
    drive    = is_init_i ? (ph.addr | ph.wdat) : ph.rdat;
    data_arm = chk_en_i & (is_init_i ? ph.rdat : ph.wdat);
    addr_arm = chk_en_i & ~is_init_i & ph.addr;
  end

  bpar_drive u_drv (
    .clk(clk), .rst_n(rst_q), .drive_i(drive), .odd_i(odd),
    .par_o(par_o), .oe_o(par_oe_o)
  );

  bpar_check u_dchk (
    .clk(clk), .rst_n(rst_q), .arm_i(data_arm), .odd_i(odd),
    .par_i(par_i), .err_o(data_err)
  );

  bpar_check u_achk (
    .clk(clk), .rst_n(rst_q), .arm_i(addr_arm), .odd_i(odd),
    .par_i(par_i), .err_o(addr_err)
  );

  assign perr_n_o = ~data_err;
  assign serr_n_o = ~addr_err;
endmodule

// File: rtl/bus_par_unit_chk.sv
module bus_par_unit_chk #(
  parameter int ADW  = 32,
  parameter int CBEW = 4
) (
  input logic            clk,
  input logic            rst_q,
  input logic [ADW-1:0]  ad_i,
  input logic [CBEW-1:0] cbe_i,
  input logic            par_i,
  input logic            addr_ph_i,
  input logic            wdat_ph_i,
  input logic            rdat_ph_i,
  input logic            is_init_i,
  input logic            chk_en_i,
  input logic            par_o,
  input logic            par_oe_o,
  input logic            perr_n_o,
  input logic            serr_n_o
);
  p_even_r1: assert property (@(posedge clk) disable iff (!rst_q)
    par_oe_o |-> !(^{par_o, $past(ad_i), $past(cbe_i)}));

  p_drive_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (is_init_i ? (addr_ph_i | wdat_ph_i) : rdat_ph_i) |=> par_oe_o);

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_q)
    !(is_init_i ? (addr_ph_i | wdat_ph_i) : rdat_ph_i) |=> (!par_oe_o && !par_o));

  p_perr_src_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !perr_n_o |-> ($past(is_init_i, 2) ? $past(rdat_ph_i, 2) : $past(wdat_ph_i, 2)));

  p_perr_bad_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !perr_n_o |-> ($past(par_i) != ^{$past(ad_i, 2), $past(cbe_i, 2)}));

  p_serr_src_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !serr_n_o |-> ($past(addr_ph_i, 2) && !$past(is_init_i, 2)));

  p_serr_bad_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !serr_n_o |-> ($past(par_i) != ^{$past(ad_i, 2), $past(cbe_i, 2)}));

  p_chk_off_r7: assert property (@(posedge clk) disable iff (!rst_q)
    !$past(chk_en_i, 2) |-> (perr_n_o && serr_n_o));
endmodule

bind bus_par_unit bus_par_unit_chk #(.ADW(ADW), .CBEW(CBEW)) u_chk (
  .clk(clk), .rst_q(rst_q), .ad_i(ad_i), .cbe_i(cbe_i), .par_i(par_i),
  .addr_ph_i(addr_ph_i), .wdat_ph_i(wdat_ph_i), .rdat_ph_i(rdat_ph_i),
  .is_init_i(is_init_i), .chk_en_i(chk_en_i), .par_o(par_o),
  .par_oe_o(par_oe_o), .perr_n_o(perr_n_o), .serr_n_o(serr_n_o)
);

// File: tb/tb_bus_par_unit.sv
module tb_bus_par_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  typedef struct packed {
    logic        a, w, r, i, c;
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic        pin;
    logic        eoe, epar, eperr, eserr;
  } vec_t;

  // expectation fields show the outputs after this row's edge
  localparam vec_t TBL [NVEC] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0000_0000, 4'h0, 1'b0, 1'b0,1'b0,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,1'b1, 32'h0000_0001, 4'h6, 1'b0, 1'b1,1'b1,1'b1,1'b1},
    '{1'b0,1'b1,1'b0,1'b1,1'b1, 32'h0000_0003, 4'h0, 1'b0, 1'b1,1'b0,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 32'h0000_0000, 4'h0, 1'b1, 1'b0,1'b0,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b1, 32'h8000_0000, 4'h7, 1'b0, 1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b0,1'b1,1'b0,1'b1, 32'hFFFF_FFFF, 4'h1, 1'b1, 1'b1,1'b1,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 32'h0000_00FF, 4'hF, 1'b0, 1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 32'h0000_0001, 4'h0, 1'b1, 1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0000_0000, 4'h0, 1'b0, 1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0000_0000, 4'h0, 1'b0, 1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 32'h0000_0001, 4'h0, 1'b0, 1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0000_0000, 4'h0, 1'b0, 1'b0,1'b0,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0000_0007, 4'h0, 1'b0, 1'b1,1'b1,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0000_0000, 4'h0, 1'b0, 1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 32'h0000_0000, 4'h0, 1'b0, 1'b0,1'b0,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 32'h0000_0000, 4'h0, 1'b1, 1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 32'h0000_0000, 4'h0, 1'b0, 1'b0,1'b0,1'b1,1'b1}
  };

  logic        clk, rst_n;
  logic [31:0] ad;
  logic [3:0]  cbe;
  logic        pin, aph, wph, rph, init, chk;
  logic        par_o, par_oe_o, perr_n_o, serr_n_o;
  int          total, bad, cyc;

  bus_par_unit dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_i(cbe), .par_i(pin),
    .addr_ph_i(aph), .wdat_ph_i(wph), .rdat_ph_i(rph), .is_init_i(init),
    .chk_en_i(chk), .par_o(par_o), .par_oe_o(par_oe_o),
    .perr_n_o(perr_n_o), .serr_n_o(serr_n_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    aph = 0; wph = 0; rph = 0; ad = '0; cbe = '0; pin = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 2000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; cyc = 0;
    rst_n = 0; init = 0; chk = 1;
    idle();
    repeat (3) @(negedge clk);
    check("R8", "oe in reset", par_oe_o, 1'b0);
    check("R8", "par in reset", par_o, 1'b0);
    check("R8", "perr_n in reset", perr_n_o, 1'b1);
    check("R8", "serr_n in reset", serr_n_o, 1'b1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1..R7, R9, R10 through the table
    for (int k = 0; k < NVEC; k++) begin
      aph = TBL[k].a; wph = TBL[k].w; rph = TBL[k].r;
      init = TBL[k].i; chk = TBL[k].c;
      ad = TBL[k].ad; cbe = TBL[k].cbe; pin = TBL[k].pin;
      @(posedge clk);
      @(negedge clk);
      check("R3/R4", $sformatf("oe row %0d", k), par_oe_o, TBL[k].eoe);
      check("R1", $sformatf("par row %0d", k), par_o, TBL[k].epar);
      check("R5/R9/R10/R7", $sformatf("perr_n row %0d", k), perr_n_o, TBL[k].eperr);
      check("R6", $sformatf("serr_n row %0d", k), serr_n_o, TBL[k].eserr);
    end

    // R2: parity enable not visible in the phase clock itself
    idle(); init = 1; chk = 1; aph = 1; ad = 32'h1;
    #1;
    check("R2", "oe before edge", par_oe_o, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R2", "oe after edge", par_oe_o, 1'b1);
    check("R2", "par after edge", par_o, 1'b1);

    // R8: asynchronous reset clears driven parity at once
    idle();
    rst_n = 0;
    #1;
    check("R8", "oe async clear", par_oe_o, 1'b0);
    check("R8", "par async clear", par_o, 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R8: reset between a bad target write and its report drops the error
    init = 0; wph = 1; ad = 32'h1;
    @(posedge clk); @(negedge clk);
    idle(); pin = 0;
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    check("R8", "pending perr dropped", perr_n_o, 1'b1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R8", "perr after release", perr_n_o, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule